// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide host-facing register port of an eight-line interrupt controller. It has two addresses. It takes host writes and turns them into configuration state, mode flags and single-cycle command strobes. It also answers host reads. The request latch, the in-service latch and the priority resolver sit outside this block. They give it the current winning line and the two latches' contents. In return the block drives an acknowledge strobe and the command strobes that tell those parts to retire or rotate.

Writes to the command address (address 0) come in three kinds, decided by bits 4 and 3. One kind starts an initialization sequence. One kind changes read and poll modes. One kind carries end-of-interrupt and priority commands coded in bits 7:5. While the controller is idle, writes to the data address (address 1) load the mask. During initialization they walk through the vector-base, cascade and mode words instead. When a poll is armed, the next read acknowledges the current winner and returns its line. An interrupt-acknowledge input also returns the vector, formed from the stored base and the winning line.

Top module: `irqc_cmd_if`

## Requirements
- R1: After reset the mask, vector base, all mode flags and all strobes are 0, no poll is armed, and a read of address 0 returns the request register.
- R2: A write to address 0 with bit 4 set pulses `init_clr` for the next cycle only. It clears the mask, vector base, poll, read select, special mask, rotate-on-auto-EOI, auto-EOI and fully nested mode. It latches bit 1 as single mode and bit 0 as "mode word follows".
- R3: The first address-1 write after the start word stores `wdata & 8'hF8` as the vector base. The sequence then ends if single mode is set and no mode word follows. It goes to the mode word if single mode is set and a mode word follows. Otherwise it goes to the cascade word.
- R4: The cascade word is accepted and discarded. It leads to the mode word if one follows, or else back to idle. The mode word sets fully nested mode from bit 4 and auto-EOI from bit 1, then returns to idle.
- R5: The mask register changes only on an address-1 write while idle, or on a start word. Initialization words leave it unchanged.
- R6: Bit 3 of the start word (level-triggered request) has no effect on any output.
- R7: An address-0 write with bit 4 = 0 and bit 3 = 1 is a mode word. Bit 2 = 1 arms poll. Bit 1 = 1 loads read select from bit 0 (1 = in-service, 0 = request). Bit 6 = 1 loads the special-mask flag from bit 5. Fields whose enable bit is clear are left unchanged.
- R8: An address-0 write with bits 4:3 = 00 is an operational command with opcode bits 7:5 and line bits 2:0. Opcodes 1, 3, 5 and 7 each pulse `eoi_req` for one cycle. `eoi_specific` is 1 for opcodes 3 and 7, `eoi_rotate` is 1 for opcodes 5 and 7, and `eoi_line` is bits 2:0.
- R9: Opcode 0 clears and opcode 4 sets the rotate-on-auto-EOI flag. Opcode 6 pulses `prio_set` with `prio_line` = bits 2:0. Opcode 2 produces no strobe and changes no flag.
- R10: A read with poll armed returns `8'h80 | win_line` and pulses `ack_pulse` in the same cycle if a winner is present, or returns 0 without acknowledging. Poll is then disarmed.
- R11: A read without poll returns the mask at address 1. At address 0 it returns the in-service register when read select is 1 and the request register when it is 0.
- R12: `vec_out` is always `vec_base | win_line` when a winner is present and `vec_base | 7` when none is. `inta` with a winner pulses `ack_pulse` with `ack_line = win_line`. `inta` with no winner does not pulse `ack_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irr_in | input | 8 | Request register from the request latch |
| isr_in | input | 8 | In-service register from the service latch |
| win_valid | input | 1 | Priority resolver has a winner |
| win_line | input | 3 | Winning line |
| inta | input | 1 | Interrupt acknowledge cycle |
| ack_pulse | output | 1 | Acknowledge the winner this cycle |
| ack_line | output | 3 | Line being acknowledged |
| vec_out | output | 8 | Vector for the acknowledge cycle |
| vec_base | output | 8 | Stored vector base, low three bits zero |
| imr | output | 8 | Mask register |
| single_mode | output | 1 | No cascade word in the sequence |
| fully_nested | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| special_mask | output | 1 | Special mask mode |
| init_clr | output | 1 | One-cycle pulse: clear request, service and priority state |
| eoi_req | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_specific | output | 1 | EOI names a line (else highest in service) |
| eoi_rotate | output | 1 | EOI also rotates priority |
| eoi_line | output | 3 | Line for a specific EOI |
| prio_set | output | 1 | One-cycle set-lowest-priority strobe |
| prio_line | output | 3 | Line to make lowest priority |

## Verification
The sequence step is not visible at the ports. A wrong step shows up as a mask that loads, or fails to load, on the first address-1 write after the expected end of the sequence. It can also show up as mode-word bits landing in the wrong place. The bench therefore ends every start-word combination with a mask write and checks it on the next cycle. A wrong read-select or poll flag shows up on the very next read, as the wrong register, a missing acknowledge or a poll that repeats. Decode errors in the command words show up one cycle after the write, on the strobes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BYTE_W = 8;
    localparam int LINE_W = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_st_e;

    typedef enum logic [1:0] {
        WK_START,
        WK_MODE,
        WK_OPER
    } wkind_e;

    // Operational opcode, bits 7:5 of an operational command word
    typedef enum logic [2:0] {
        OP_RAEOI_CLR = 3'd0,
        OP_NS_EOI    = 3'd1,
        OP_NOP       = 3'd2,
        OP_SP_EOI    = 3'd3,
        OP_RAEOI_SET = 3'd4,
        OP_RNS_EOI   = 3'd5,
        OP_SET_PRIO  = 3'd6,
        OP_RSP_EOI   = 3'd7
    } opcode_e;

    typedef struct packed {
        logic              req;
        logic              specific;
        logic              rotate;
        logic [LINE_W-1:0] line;
    } eoi_cmd_t;

    function automatic wkind_e classify(input logic [BYTE_W-1:0] d);
        if (d[4])      return WK_START;
        else if (d[3]) return WK_MODE;
        else           return WK_OPER;
    endfunction

    function automatic seq_st_e after_base(input logic single, input logic need_mode);
        if (!single)        return SEQ_CASC;
        else if (need_mode) return SEQ_MODE;
        else                return SEQ_IDLE;
    endfunction

endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wdata,
    output logic              init_start,
    output logic              init_clr,
    output logic [BYTE_W-1:0] vec_base,
    output logic [BYTE_W-1:0] imr,
    output logic              single_mode,
    output logic              fully_nested,
    output logic              auto_eoi
);

    seq_st_e st;
    logic    need_mode;

    assign init_start = wr_cmd && (classify(wdata) == WK_START);

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= SEQ_IDLE;
            need_mode    <= 1'b0;
            init_clr     <= 1'b0;
            vec_base     <= '0;
            imr          <= '0;
            single_mode  <= 1'b0;
            fully_nested <= 1'b0;
            auto_eoi     <= 1'b0;
        end else begin
            init_clr <= init_start;
            if (init_start) begin
                // bit 3 (level request) deliberately not stored
                st           <= SEQ_BASE;
                need_mode    <= wdata[0];
                single_mode  <= wdata[1];
                vec_base     <= '0;
                imr          <= '0;
                fully_nested <= 1'b0;
                auto_eoi     <= 1'b0;
            end else if (wr_data) begin
                unique case (st)
                    SEQ_IDLE: imr <= wdata;
                    SEQ_BASE: begin
                        vec_base <= {wdata[BYTE_W-1:LINE_W], {LINE_W{1'b0}}};
                        st       <= after_base(single_mode, need_mode);
                    end
                    SEQ_CASC: st <= need_mode ? SEQ_MODE : SEQ_IDLE;
                    SEQ_MODE: begin
                        fully_nested <= wdata[4];
                        auto_eoi     <= wdata[1];
                        st           <= SEQ_IDLE;
                    end
                    default: st <= SEQ_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/irqc_ocw_dec.sv
module irqc_ocw_dec
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic              init_start,
    input  logic              poll_take,
    input  logic [BYTE_W-1:0] wdata,
    output logic              poll_armed,
    output logic              read_isr,
    output logic              special_mask,
    output logic              rot_aeoi,
    output eoi_cmd_t          eoi,
    output logic              prio_set,
    output logic [LINE_W-1:0] prio_line
);

    logic    mode_wr;
    logic    oper_wr;
    opcode_e op;

    assign mode_wr = wr_cmd && (classify(wdata) == WK_MODE);
    assign oper_wr = wr_cmd && (classify(wdata) == WK_OPER);
    assign op      = opcode_e'(wdata[7:5]);

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_armed   <= 1'b0;
            read_isr     <= 1'b0;
            special_mask <= 1'b0;
            rot_aeoi     <= 1'b0;
            eoi          <= '0;
            prio_set     <= 1'b0;
            prio_line    <= '0;
        end else begin
            eoi.req  <= 1'b0;
            prio_set <= 1'b0;
            if (init_start) begin
                poll_armed   <= 1'b0;
                read_isr     <= 1'b0;
                special_mask <= 1'b0;
                rot_aeoi     <= 1'b0;
            end else begin
                if (mode_wr && wdata[2])
                    poll_armed <= 1'b1;
                else if (poll_take)
                    poll_armed <= 1'b0;
                if (mode_wr && wdata[1])
                    read_isr <= wdata[0];
                if (mode_wr && wdata[6])
                    special_mask <= wdata[5];
                if (oper_wr) begin
                    unique case (op)
                        OP_RAEOI_CLR: rot_aeoi <= 1'b0;
                        OP_RAEOI_SET: rot_aeoi <= 1'b1;
                        OP_NS_EOI:    eoi <= '{req: 1'b1, specific: 1'b0, rotate: 1'b0, line: wdata[2:0]};
                        OP_RNS_EOI:   eoi <= '{req: 1'b1, specific: 1'b0, rotate: 1'b1, line: wdata[2:0]};
                        OP_SP_EOI:    eoi <= '{req: 1'b1, specific: 1'b1, rotate: 1'b0, line: wdata[2:0]};
                        OP_RSP_EOI:   eoi <= '{req: 1'b1, specific: 1'b1, rotate: 1'b1, line: wdata[2:0]};
                        OP_SET_PRIO: begin
                            prio_set  <= 1'b1;
                            prio_line <= wdata[2:0];
                        end
                        OP_NOP: ;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/irqc_rd_port.sv
module irqc_rd_port
    import irqc_pkg::*;
(
    input  logic              rd_en,
    input  logic              addr,
    input  logic              inta,
    input  logic              poll_armed,
    input  logic              read_isr,
    input  logic [BYTE_W-1:0] irr_in,
    input  logic [BYTE_W-1:0] isr_in,
    input  logic [BYTE_W-1:0] imr,
    input  logic [BYTE_W-1:0] vec_base,
    input  logic              win_valid,
    input  logic [LINE_W-1:0] win_line,
    output logic [BYTE_W-1:0] rdata,
    output logic              poll_take,
    output logic              ack_pulse,
    output logic [LINE_W-1:0] ack_line,
    output logic [BYTE_W-1:0] vec_out
);

    localparam logic [LINE_W-1:0] SPURIOUS = '1;

    logic [BYTE_W-1:0] poll_word;
    logic [LINE_W-1:0] vec_line;

    assign poll_take = rd_en && poll_armed;
    assign poll_word = win_valid ? {1'b1, {(BYTE_W-LINE_W-1){1'b0}}, win_line} : '0;

    always_comb begin
        if (poll_armed)
            rdata = poll_word;
        else if (addr)
            rdata = imr;
        else if (read_isr)
            rdata = isr_in;
        else
            rdata = irr_in;
    end

    assign ack_pulse = win_valid && (inta || poll_take);
    assign ack_line  = win_line;
    assign vec_line  = win_valid ? win_line : SPURIOUS;
    assign vec_out   = vec_base | {{(BYTE_W-LINE_W){1'b0}}, vec_line};

endmodule

// File: rtl/irqc_cmd_if.sv
module irqc_cmd_if
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [BYTE_W-1:0] irr_in,
    input  logic [BYTE_W-1:0] isr_in,
    input  logic              win_valid,
    input  logic [LINE_W-1:0] win_line,
    input  logic              inta,
    output logic              ack_pulse,
    output logic [LINE_W-1:0] ack_line,
    output logic [BYTE_W-1:0] vec_out,
    output logic [BYTE_W-1:0] vec_base,
    output logic [BYTE_W-1:0] imr,
    output logic              single_mode,
    output logic              fully_nested,
    output logic              auto_eoi,
    output logic              rot_aeoi,
    output logic              special_mask,
    output logic              init_clr,
    output logic              eoi_req,
    output logic              eoi_specific,
    output logic              eoi_rotate,
    output logic [LINE_W-1:0] eoi_line,
    output logic              prio_set,
    output logic [LINE_W-1:0] prio_line
);

    logic     wr_cmd;
    logic     wr_data;
    logic     init_start;
    logic     poll_armed;
    logic     poll_take;
    logic     read_isr;
    eoi_cmd_t eoi;

    assign wr_cmd  = wr_en && !addr;
    assign wr_data = wr_en && addr;

    irqc_init_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .wr_cmd       (wr_cmd),
        .wr_data      (wr_data),
        .wdata        (wdata),
        .init_start   (init_start),
        .init_clr     (init_clr),
        .vec_base     (vec_base),
        .imr          (imr),
        .single_mode  (single_mode),
        .fully_nested (fully_nested),
        .auto_eoi     (auto_eoi)
    );

    irqc_ocw_dec u_dec (
        .clk          (clk),
        .rst          (rst),
        .wr_cmd       (wr_cmd),
        .init_start   (init_start),
        .poll_take    (poll_take),
        .wdata        (wdata),
        .poll_armed   (poll_armed),
        .read_isr     (read_isr),
        .special_mask (special_mask),
        .rot_aeoi     (rot_aeoi),
        .eoi          (eoi),
        .prio_set     (prio_set),
        .prio_line    (prio_line)
    );

    irqc_rd_port u_rd (
        .rd_en      (rd_en),
        .addr       (addr),
        .inta       (inta),
        .poll_armed (poll_armed),
        .read_isr   (read_isr),
        .irr_in     (irr_in),
        .isr_in     (isr_in),
        .imr        (imr),
        .vec_base   (vec_base),
        .win_valid  (win_valid),
        .win_line   (win_line),
        .rdata      (rdata),
        .poll_take  (poll_take),
        .ack_pulse  (ack_pulse),
        .ack_line   (ack_line),
        .vec_out    (vec_out)
    );

    assign eoi_req      = eoi.req;
    assign eoi_specific = eoi.specific;
    assign eoi_rotate   = eoi.rotate;
    assign eoi_line     = eoi.line;

endmodule

// File: rtl/irqc_cmd_if_chk.sv
module irqc_cmd_if_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic       win_valid,
    input logic       inta,
    input logic [7:0] imr,
    input logic       init_clr,
    input logic       eoi_req,
    input logic       prio_set,
    input logic       ack_pulse
);

    p_init_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        init_clr |-> $past(wr_en && !addr && wdata[4]));

    p_mask_write_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(imr) |-> $past(wr_en));

    p_eoi_from_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        eoi_req |-> $past(wr_en && !addr && wdata[4:3] == 2'b00 && wdata[5]));

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eoi_req, prio_set, init_clr}));

    p_prio_from_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        prio_set |-> $past(wr_en && !addr && wdata[7:3] == 5'b11000));

    p_poll_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_pulse && !inta) |-> rd_en);

    p_ack_winner_r12: assert property (@(posedge clk) disable iff (rst)
        ack_pulse |-> win_valid);

endmodule

bind irqc_cmd_if irqc_cmd_if_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .win_valid (win_valid),
    .inta      (inta),
    .imr       (imr),
    .init_clr  (init_clr),
    .eoi_req   (eoi_req),
    .prio_set  (prio_set),
    .ack_pulse (ack_pulse)
);

// File: tb/irqc_cmd_if_tb.sv
`timescale 1ns/1ps
module irqc_cmd_if_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
    logic [7:0] wdata = '0, irr_in = '0, isr_in = '0;
    logic       win_valid = 1'b0;
    logic [2:0] win_line = '0;
    logic [7:0] rdata, vec_out, vec_base, imr;
    logic       ack_pulse, single_mode, fully_nested, auto_eoi, rot_aeoi, special_mask;
    logic       init_clr, eoi_req, eoi_specific, eoi_rotate, prio_set;
    logic [2:0] ack_line, eoi_line, prio_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irqc_cmd_if dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
        .win_valid(win_valid), .win_line(win_line), .inta(inta),
        .ack_pulse(ack_pulse), .ack_line(ack_line), .vec_out(vec_out),
        .vec_base(vec_base), .imr(imr), .single_mode(single_mode),
        .fully_nested(fully_nested), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
        .special_mask(special_mask), .init_clr(init_clr), .eoi_req(eoi_req),
        .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate), .eoi_line(eoi_line),
        .prio_set(prio_set), .prio_line(prio_line)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] q, output logic ak);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        q  = rdata;
        ak = ack_pulse;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        logic       ak;
        logic       e_poll, e_rsel, e_sm, e_rot;

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        irr_in = 8'h5A; isr_in = 8'hA5;
        #1;
        // R1 reset state
        chk("R1 imr", imr, 0);
        chk("R1 vec_base", vec_base, 0);
        chk("R1 flags", {single_mode, fully_nested, auto_eoi, rot_aeoi, special_mask}, 0);
        chk("R1 strobes", {init_clr, eoi_req, prio_set}, 0);
        win_valid = 1'b1; win_line = 3'd4;
        rd(1'b0, q, ak);
        chk("R1 read irr", q, 8'h5A);
        chk("R1 no poll ack", ak, 0);

        // Start-word flag sweep: R2 R3 R4 R5 R6
        for (int f = 0; f < 8; f++) begin
            logic n4, sg;
            logic [7:0] b, m;
            n4 = f[0]; sg = f[1];
            b  = 8'(f * 37 + 19);
            m  = 8'hC3 ^ 8'(f);
            wr(1'b1, 8'hFF);
            chk("R5 idle mask load", imr, 8'hFF);
            wr(1'b0, 8'h6F);
            chk("R7 special mask set", special_mask, 1);
            wr(1'b0, 8'h10 | {4'b0, f[2], 1'b0, sg, n4});
            chk("R2 init_clr pulse", init_clr, 1);
            chk("R2 mask cleared", imr, 0);
            chk("R2 special mask cleared", special_mask, 0);
            win_valid = 1'b1; win_line = 3'd5;
            rd(1'b0, q, ak);
            chk("R2 poll/select cleared rdata", q, 8'h5A);
            chk("R2 poll cleared ack", ak, 0);
            chk("R2 init_clr one cycle", init_clr, 0);
            wr(1'b1, b);
            chk("R3 vec_base", vec_base, b & 8'hF8);
            chk("R5 mask kept in base word", imr, 0);
            chk("R3 single_mode", single_mode, sg);
            if (!sg) begin
                wr(1'b1, 8'hFF);
                chk("R4 cascade word no mask", imr, 0);
            end
            if (n4) begin
                wr(1'b1, 8'h12);
                chk("R5 mask kept in mode word", imr, 0);
            end
            chk("R4 R6 fully_nested", fully_nested, n4);
            chk("R4 R6 auto_eoi", auto_eoi, n4);
            wr(1'b1, m);
            chk("R5 R6 mask after sequence", imr, m);
            chk("R6 vec_base unchanged", vec_base, b & 8'hF8);
        end

        // Vector base sweep and acknowledge vector: R3 R12
        for (int b = 0; b < 256; b++) begin
            logic [7:0] eb;
            eb = 8'(b) & 8'hF8;
            wr(1'b0, 8'h12);
            wr(1'b1, 8'(b));
            chk("R3 base sweep", vec_base, eb);
            @(negedge clk);
            win_valid = 1'b1; win_line = 3'(b % 8); inta = 1'b1;
            #1;
            chk("R12 vector", vec_out, eb | 8'(b % 8));
            chk("R12 ack_pulse", ack_pulse, 1);
            chk("R12 ack_line", ack_line, b % 8);
            @(negedge clk);
            win_valid = 1'b0;
            #1;
            chk("R12 spurious vector", vec_out, eb | 8'h07);
            chk("R12 spurious no ack", ack_pulse, 0);
            @(posedge clk);
            #1 inta = 1'b0;
        end

        // Operational commands: R8 R9
        e_rot = 1'b0;
        for (int c = 0; c < 8; c++) begin
            for (int l = 0; l < 8; l++) begin
                bit ee, es, er, ep;
                ee = (c == 1) || (c == 3) || (c == 5) || (c == 7);
                es = (c == 3) || (c == 7);
                er = (c == 5) || (c == 7);
                ep = (c == 6);
                if (c == 0) e_rot = 1'b0;
                if (c == 4) e_rot = 1'b1;
                wr(1'b0, {3'(c), 2'b00, 3'(l)});
                chk("R8 eoi_req", eoi_req, ee);
                if (ee) begin
                    chk("R8 eoi_specific", eoi_specific, es);
                    chk("R8 eoi_rotate", eoi_rotate, er);
                    if (es) chk("R8 eoi_line", eoi_line, l);
                end
                chk("R9 prio_set", prio_set, ep);
                if (ep) chk("R9 prio_line", prio_line, l);
                chk("R9 rot_aeoi", rot_aeoi, e_rot);
                chk("R9 no init pulse", init_clr, 0);
                @(posedge clk); #1;
                chk("R8 strobe one cycle", {eoi_req, prio_set}, 0);
            end
        end

        // Mode words, poll and register reads: R7 R10 R11
        wr(1'b1, 8'h96);
        e_poll = 1'b0; e_rsel = 1'b0; e_sm = 1'b0;
        for (int k = 0; k < 32; k++) begin
            logic [7:0] d, ex;
            logic a;
            d = 8'h08 | {1'b0, k[4], k[3], 2'b00, k[2], k[1], k[0]};
            if (k[2]) e_poll = 1'b1;
            if (k[1]) e_rsel = k[0];
            if (k[4]) e_sm = k[3];
            wr(1'b0, d);
            chk("R7 special_mask", special_mask, e_sm);
            irr_in = 8'h3C ^ 8'(k); isr_in = 8'hC1 ^ 8'(k);
            win_valid = (k % 3) != 0; win_line = 3'(k % 8);
            a = k[0] ^ k[3];
            rd(a, q, ak);
            if (e_poll) begin
                ex = win_valid ? (8'h80 | 8'(k % 8)) : 8'h00;
                chk("R10 poll rdata", q, ex);
                chk("R10 poll ack", ak, win_valid);
                e_poll = 1'b0;
            end else begin
                ex = a ? 8'h96 : (e_rsel ? isr_in : irr_in);
                chk("R11 R7 rdata", q, ex);
                chk("R11 no ack", ak, 0);
            end
            rd(1'b0, q, ak);
            chk("R10 R11 read after poll", q, e_rsel ? isr_in : irr_in);
            chk("R10 poll disarmed", ak, 0);
            rd(1'b1, q, ak);
            chk("R11 mask read", q, 8'h96);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule